// File: doc/BRIEF.md
# Programmable CRC Engine with Input FIFO

This block computes a cyclic redundancy check whose length (1 to 16 bits) and feedback taps are chosen at run time. Software pushes data entries into an input FIFO through a plain write strobe. A serial shifter takes one entry at a time from the FIFO. It folds the entry into the remainder one bit per clock, most significant bit first. The remainder can be seeded before a run and read back at any time.

The entry width and the FIFO capacity both follow the programmed length. For CRCs of 8 bits or fewer, entries are bytes and the FIFO holds up to sixteen of them. For longer CRCs, entries are 16-bit words and the FIFO holds up to eight of them. A start bit turns the shifter on. When start is cleared, the shifter keeps working until the FIFO and the current entry are used up, and only then turns off. An idle-stop bit freezes the shifter while the device-idle input is high.

Top module: `crc_fifo_engine`

## Requirements
- R1: After reset, the FIFO count is 0, full is 0, empty is 1, the remainder and tap registers read 0, and the control readback is 0x0040.
- R2: The control readback places its fields as follows: bit 13 is idle-stop, bits 12:8 are the FIFO count, bit 7 is full, bit 6 is empty, bit 4 is start, and bits 3:0 are the length field (CRC length minus one). Bits 15, 14 and 5 always read 0. The count, full and empty fields ignore writes.
- R3: When the length field is 7 or less, the FIFO capacity is 16. When it is 8 or more, the capacity is 8. Full is 1 exactly when the count equals the capacity, and full and empty are never both 1.
- R4: A data write while the FIFO is full is dropped and leaves the count unchanged.
- R5: Each accepted data write raises the count by one. Between two clock edges, the count changes by at most one.
- R6: Entries are the low 8 bits of the written data when the length field is 7 or less, and all 16 bits otherwise. Each bit, MSB first, gives a feedback bit equal to the data bit XOR the remainder bit at index length-field. The remainder is shifted left, XORed with the tap register when the feedback bit is 1, and masked to the CRC length.
- R7: With start never set, pushed entries stay in the FIFO and the remainder does not change. After start is cleared, the FIFO still drains fully into the remainder, and then the shifter stops, so later pushes stay queued.
- R8: With idle-stop set and the idle input high, the shifter makes no progress. With idle-stop clear, the shifter keeps running while the idle input is high.
- R9: A remainder write seeds the remainder, masked to the current CRC length. The tap register reads back the value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idleIn | input | 1 | Device idle indication |
| ctrlWrEn | input | 1 | Write wrData to the control register |
| polyWrEn | input | 1 | Write wrData to the tap register |
| remWrEn | input | 1 | Seed the remainder from wrData |
| dataWrEn | input | 1 | Push wrData into the FIFO |
| wrData | input | 16 | Shared write data |
| ctrlRdData | output | 16 | Control and status readback |
| polyRdData | output | 16 | Tap register readback |
| remRdData | output | 16 | Current remainder |
| fifoCount | output | 5 | Valid FIFO entries |
| fifoFull | output | 1 | FIFO at capacity |
| fifoEmpty | output | 1 | FIFO holds no entries |

## Verification
Errors in the FIFO pointers or count appear at the status ports on the same edge as the faulty push or pop. They show up as a count that skips a step, passes the capacity, or never reaches it. An error in the bit counter or in the feedback path does not show at once: the remainder is only compared after an entry has drained, so the fault appears one entry time later (9 or 17 cycles). The sweep covers every length field with its own taps and seed, so a wrong mask, a wrong top-bit index or a wrong entry width produces a wrong remainder at that length.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;
  localparam int DATA_W       = 16;
  localparam int NARROW_W     = 8;
  localparam int DEPTH_NARROW = 16;
  localparam int DEPTH_WIDE   = 8;
  localparam int PTR_W        = $clog2(DEPTH_NARROW);
  localparam int CNT_W        = PTR_W + 1;
  localparam int LEN_W        = $clog2(DATA_W);
  localparam int BIT_W        = $clog2(DATA_W) + 1;

  typedef struct packed {
    logic push;
    logic load;
    logic shift;
    logic remWr;
    logic polyWr;
    logic wide;
  } strobe_t;
endpackage

// File: rtl/crc_eng_ctrl.sv
module crc_eng_ctrl
  import crc_eng_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idleIn,
  input  logic                ctrlWrEn,
  input  logic                polyWrEn,
  input  logic                remWrEn,
  input  logic                dataWrEn,
  input  logic [DATA_W-1:0]   wrData,
  output strobe_t             stb,
  output logic [PTR_W-1:0]    wrPtr,
  output logic [PTR_W-1:0]    rdPtr,
  output logic [LEN_W-1:0]    lenField,
  output logic [15:0]         ctrlRdData,
  output logic [CNT_W-1:0]    fifoCount,
  output logic                fifoFull,
  output logic                fifoEmpty
);
  logic             goBit, idleStop, shOn;
  logic [BIT_W-1:0] bitsLeft;
  logic [CNT_W-1:0] maxDepth;
  logic             wide, suspend, active, push, load, shift, workLeft;

  always_comb begin
    wide      = (lenField >= LEN_W'(NARROW_W));
    maxDepth  = wide ? CNT_W'(DEPTH_WIDE) : CNT_W'(DEPTH_NARROW);
    fifoFull  = (fifoCount == maxDepth);
    fifoEmpty = (fifoCount == '0);
    suspend   = idleStop & idleIn;
    active    = (goBit | shOn) & ~suspend;
    load      = active && (bitsLeft == '0) && !fifoEmpty;
    shift     = active && (bitsLeft != '0);
    push      = dataWrEn && !fifoFull;
    workLeft  = !fifoEmpty || (bitsLeft != '0);
    stb.push   = push;
    stb.load   = load;
    stb.shift  = shift;
    stb.remWr  = remWrEn;
    stb.polyWr = polyWrEn;
    stb.wide   = wide;
    ctrlRdData = {2'b00, idleStop, fifoCount, fifoFull, fifoEmpty,
                  1'b0, goBit, lenField};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      goBit     <= 1'b0;
      idleStop  <= 1'b0;
      lenField  <= '0;
      shOn      <= 1'b0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
      bitsLeft  <= '0;
    end else begin
      if (ctrlWrEn) begin
        idleStop <= wrData[13];
        goBit    <= wrData[4];
        lenField <= wrData[LEN_W-1:0];
      end
      shOn <= goBit | (shOn & workLeft);
      if (push) wrPtr <= wrPtr + 1'b1;
      if (load) rdPtr <= rdPtr + 1'b1;
      if (push && !load)      fifoCount <= fifoCount + 1'b1;
      else if (load && !push) fifoCount <= fifoCount - 1'b1;
      if (load)       bitsLeft <= wide ? BIT_W'(DATA_W) : BIT_W'(NARROW_W);
      else if (shift) bitsLeft <= bitsLeft - 1'b1;
    end
  end
endmodule

// File: rtl/crc_eng_dp.sv
module crc_eng_dp
  import crc_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [LEN_W-1:0]  lenField,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] polyRdData,
  output logic [DATA_W-1:0] remRdData
);
  logic [DATA_W-1:0] fifoMem [DEPTH_NARROW];
  logic [DATA_W-1:0] shReg, remReg, polyReg, mask, remNext;
  logic              feedBit;

  always_comb begin
    mask    = ~({DATA_W{1'b1}} << ((LEN_W+1)'(lenField) + (LEN_W+1)'(1)));
    feedBit = shReg[DATA_W-1] ^ remReg[lenField];
    remNext = ((remReg << 1) ^ (feedBit ? polyReg : '0)) & mask;
    polyRdData = polyReg;
    remRdData  = remReg;
  end

  always_ff @(posedge clk) begin
    if (stb.push) fifoMem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shReg   <= '0;
      remReg  <= '0;
      polyReg <= '0;
    end else begin
      if (stb.polyWr) polyReg <= wrData;
      if (stb.load)
        shReg <= stb.wide ? fifoMem[rdPtr] : (fifoMem[rdPtr] << (DATA_W - NARROW_W));
      else if (stb.shift)
        shReg <= shReg << 1;
      if (stb.remWr)      remReg <= wrData & mask;
      else if (stb.shift) remReg <= remNext;
    end
  end
endmodule

// File: rtl/crc_fifo_engine.sv
module crc_fifo_engine
  import crc_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idleIn,
  input  logic              ctrlWrEn,
  input  logic              polyWrEn,
  input  logic              remWrEn,
  input  logic              dataWrEn,
  input  logic [15:0]       wrData,
  output logic [15:0]       ctrlRdData,
  output logic [15:0]       polyRdData,
  output logic [15:0]       remRdData,
  output logic [4:0]        fifoCount,
  output logic              fifoFull,
  output logic              fifoEmpty
);
  strobe_t          stb;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [LEN_W-1:0] lenField;

  crc_eng_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .idleIn(idleIn), .ctrlWrEn(ctrlWrEn),
    .polyWrEn(polyWrEn), .remWrEn(remWrEn), .dataWrEn(dataWrEn),
    .wrData(wrData), .stb(stb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .lenField(lenField), .ctrlRdData(ctrlRdData), .fifoCount(fifoCount),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty)
  );

  crc_eng_dp u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .lenField(lenField), .wrData(wrData), .polyRdData(polyRdData),
    .remRdData(remRdData)
  );
endmodule

// File: rtl/crc_fifo_engine_chk.sv
module crc_fifo_engine_chk
  import crc_eng_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        idleIn,
  input logic        ctrlWrEn,
  input logic        remWrEn,
  input logic        dataWrEn,
  input logic [15:0] ctrlRdData,
  input logic [15:0] remRdData,
  input logic [4:0]  fifoCount,
  input logic        fifoFull,
  input logic        fifoEmpty
);
  logic [4:0] capNow;
  logic       frozen;
  assign capNow = (ctrlRdData[3:0] >= 4'(NARROW_W)) ? 5'(DEPTH_WIDE) : 5'(DEPTH_NARROW);
  assign frozen = ctrlRdData[13] & idleIn;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifoCount <= capNow); // R3
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifoFull && fifoEmpty)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (fifoFull && dataWrEn && !ctrlWrEn) |=> fifoCount <= $past(fifoCount)); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fifoCount == $past(fifoCount)) || (fifoCount == $past(fifoCount) + 5'd1)
             || (fifoCount + 5'd1 == $past(fifoCount))); // R5
  AST_IDLE_REM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !remWrEn && !ctrlWrEn) |=> $stable(remRdData)); // R8
  AST_IDLE_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !dataWrEn && !ctrlWrEn) |=> fifoCount == $past(fifoCount)); // R8
endmodule

bind crc_fifo_engine crc_fifo_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .idleIn(idleIn), .ctrlWrEn(ctrlWrEn),
  .remWrEn(remWrEn), .dataWrEn(dataWrEn), .ctrlRdData(ctrlRdData),
  .remRdData(remRdData), .fifoCount(fifoCount), .fifoFull(fifoFull),
  .fifoEmpty(fifoEmpty)
);

// File: tb/tb_crc_fifo_engine.sv
module tb_crc_fifo_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idleIn = 1'b0;
  logic        ctrlWrEn = 1'b0, polyWrEn = 1'b0, remWrEn = 1'b0, dataWrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] ctrlRdData, polyRdData, remRdData;
  logic [4:0]  fifoCount;
  logic        fifoFull, fifoEmpty;

  int nTests = 0;
  int nFail  = 0;
  int cycles = 0;

  crc_fifo_engine dut (
    .clk(clk), .rst_n(rst_n), .idleIn(idleIn), .ctrlWrEn(ctrlWrEn),
    .polyWrEn(polyWrEn), .remWrEn(remWrEn), .dataWrEn(dataWrEn),
    .wrData(wrData), .ctrlRdData(ctrlRdData), .polyRdData(polyRdData),
    .remRdData(remRdData), .fifoCount(fifoCount), .fifoFull(fifoFull),
    .fifoEmpty(fifoEmpty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nFail = nFail + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nTests = nTests + 1;
    if (act != exp) begin
      nFail = nFail + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // kind: 0 ctrl, 1 poly, 2 rem, 3 data
  task automatic wr(input int kind, input int val);
    @(negedge clk);
    wrData   = 16'(val);
    ctrlWrEn = (kind == 0);
    polyWrEn = (kind == 1);
    remWrEn  = (kind == 2);
    dataWrEn = (kind == 3);
    @(negedge clk);
    ctrlWrEn = 1'b0; polyWrEn = 1'b0; remWrEn = 1'b0; dataWrEn = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int refStep(input int rem, input int poly, input int lenF, input int entry);
    int crcLen = lenF + 1;
    int width  = (lenF >= 8) ? 16 : 8;
    int modv   = 1 << crcLen;
    int r      = rem % modv;
    for (int i = width - 1; i >= 0; i--) begin
      int d = (entry >> i) & 1;
      int t = (r >> (crcLen - 1)) & 1;
      r = (r * 2) % modv;
      if ((d ^ t) == 1) r = r ^ (poly % modv);
    end
    return r;
  endfunction

  initial begin
    int exp;
    waitCyc(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 ctrl", ctrlRdData, 16'h0040);
    check("R1 count", fifoCount, 0);
    check("R1 full", fifoFull, 0);
    check("R1 empty", fifoEmpty, 1);
    check("R1 rem", remRdData, 0);
    check("R1 poly", polyRdData, 0);

    // R2 control layout, reserved bits read zero
    wr(0, 16'hFFFF);
    check("R2 layout all-ones", ctrlRdData, 16'h205F);
    wr(0, 16'h0000);
    check("R2 layout cleared", ctrlRdData, 16'h0040);

    // R9 seed masking and tap readback
    wr(0, 4);
    wr(2, 16'hFFFF);
    check("R9 seed masked", remRdData, 16'h001F);
    wr(1, 16'hA5C3);
    check("R9 poly readback", polyRdData, 16'hA5C3);

    // R3 R4 R5 narrow depth
    wr(0, 3);
    for (int k = 1; k <= 20; k++) begin
      wr(3, k);
      check((k > 16) ? "R4 count on full push" : "R5 count step", fifoCount, (k > 16) ? 16 : k);
      check("R3 full flag", fifoFull, (k >= 16) ? 1 : 0);
    end
    check("R2 count field", ctrlRdData, 16'h1083);
    wr(0, 16'h0013);
    waitCyc(16 * 9 + 10);
    wr(0, 3);
    check("R3 drained empty", fifoEmpty, 1);

    // R3 R4 wide depth
    wr(0, 12);
    for (int k = 1; k <= 10; k++) begin
      wr(3, k * 3);
      check((k > 8) ? "R4 wide count on full" : "R5 wide count", fifoCount, (k > 8) ? 8 : k);
      check("R3 wide full", fifoFull, (k >= 8) ? 1 : 0);
    end
    wr(0, 16'h001C);
    waitCyc(8 * 17 + 10);
    wr(0, 12);
    check("R3 wide drained", fifoCount, 0);

    // R6 sweep every length
    for (int lenF = 0; lenF < 16; lenF++) begin
      int poly = (16'h8005 ^ (lenF * 16'h1357)) & 16'hFFFF;
      int seed = (lenF * 16'h0F1 + 7) & 16'hFFFF;
      wr(0, lenF);
      wr(1, poly);
      wr(2, seed);
      exp = seed % (1 << (lenF + 1));
      for (int k = 0; k < 4; k++) begin
        int dv = (lenF * 37 + k * 4091 + 5) & 16'hFFFF;
        wr(3, dv);
        exp = refStep(exp, poly, lenF, (lenF >= 8) ? dv : (dv & 16'hFF));
      end
      wr(0, 16'h0010 | lenF);
      waitCyc(4 * 17 + 10);
      check("R6 sweep remainder", remRdData, exp);
      check("R6 sweep drained", fifoCount, 0);
      wr(0, lenF);
    end

    // R7 start semantics
    wr(0, 7);
    wr(1, 16'h07);
    wr(2, 16'h5A);
    wr(3, 16'h31);
    wr(3, 16'hC4);
    waitCyc(40);
    check("R7 no start count", fifoCount, 2);
    check("R7 no start rem", remRdData, 16'h5A);
    exp = refStep(refStep(16'h5A, 16'h07, 7, 16'h31), 16'h07, 7, 16'hC4);
    wr(0, 16'h0017);
    waitCyc(2);
    wr(0, 16'h0007);
    waitCyc(40);
    check("R7 drain after clear count", fifoCount, 0);
    check("R7 drain after clear rem", remRdData, exp);
    wr(3, 16'h99);
    waitCyc(30);
    check("R7 stopped after drain", fifoCount, 1);
    check("R7 stopped rem", remRdData, exp);
    exp = refStep(exp, 16'h07, 7, 16'h99);
    wr(0, 16'h0017);
    waitCyc(20);
    wr(0, 16'h0007);
    check("R7 restart rem", remRdData, exp);

    // R8 idle suspend
    wr(0, 16'h2007);
    idleIn = 1'b1;
    wr(0, 16'h2017);
    wr(3, 16'h12);
    wr(3, 16'hEF);
    waitCyc(50);
    check("R8 frozen count", fifoCount, 2);
    check("R8 frozen rem", remRdData, exp);
    exp = refStep(refStep(exp, 16'h07, 7, 16'h12), 16'h07, 7, 16'hEF);
    idleIn = 1'b0;
    waitCyc(40);
    check("R8 resumed count", fifoCount, 0);
    check("R8 resumed rem", remRdData, exp);
    wr(0, 16'h0017);
    idleIn = 1'b1;
    wr(3, 16'h6B);
    exp = refStep(exp, 16'h07, 7, 16'h6B);
    waitCyc(20);
    check("R8 runs in idle count", fifoCount, 0);
    check("R8 runs in idle rem", remRdData, exp);
    idleIn = 1'b0;
    wr(0, 16'h0007);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule